// File: doc/BRIEF.md
# Context-Switch Buffer Registry and Launch Selector

This block keeps four indirect command-buffer descriptors, each a 64-bit address and a 20-bit length in dwords. A command processor runs them when it switches away from a context or back to it, to save or rebuild state that the switch routine does not handle itself. Software fills a descriptor by sending a three-dword payload. The third dword names the slot by its role.

When a switch event arrives, the block works out which stored buffers apply. It looks at the cause of the switch and at whether the context was preempted inside a yield marker with a shortened save. It then issues those buffers one at a time as launch requests with a ready handshake. A separate marker input tracks the current render-mode marker. Marker values that only privileged code may set, and the privileged-only slot role, are refused from unprivileged sources, and the block pulses an error when it refuses one.

Top module: `ctxsw_ib_sel`

## Requirements
- R1: A payload is three dwords accepted on `pay_valid`. They are: address bits 31:0, then address bits 63:32, then a control dword holding the length in bits 19:0 and the slot role in bits 21:20. The role codes are 0 = restore, 1 = yield-restore, 2 = save and 3 = ring-buffer save. The slot is written at the clock edge that accepts the control dword, and a later write replaces the earlier one.
- R2: A control dword with role 3 and `pay_priv` low is dropped with no change to any slot. `err_pulse` is then high for the one cycle after that edge.
- R3: The 9-bit marker mode is written on `mark_valid`. The values 0x00D, 0x00E, 0x100 and 0x101 from a source with `mark_priv` low are dropped, the stored mode is kept, and `err_pulse` is high for one cycle. Any other value, and any value from a privileged source, replaces the mode.
- R4: Every switch back launches the restore slot.
- R5: The yield-restore slot is launched on switch back, after the restore slot, only if the previous switch away happened while the marker mode was 7 and `away_short` was high.
- R6: A switch away with `away_by_yield` low launches the ring-buffer save slot first and then the save slot. A switch away with `away_by_yield` high launches neither.
- R7: `launch_prot_off` is high only while the ring-buffer save slot is being launched.
- R8: A slot whose length is zero is empty and is never launched. After reset, all slots are empty.
- R9: The first launch appears in the cycle after the event edge. It holds its address, length and flag until `launch_ready`. The next launch appears in the cycle after the previous one is accepted.
- R10: The yield-preempted state is cleared by the switch back that handles it.
- R11: A switch event that arrives while a launch is outstanding is ignored. If `sw_away` and `sw_back` arrive together, the switch away is handled and the switch back is ignored.
- R12: Reset leaves no launch pending, `err_pulse` low and the marker mode at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pay_valid | input | 1 | Payload dword valid |
| pay_data | input | 32 | Payload dword |
| pay_priv | input | 1 | Payload comes from the privileged ring buffer |
| mark_valid | input | 1 | Marker write valid |
| mark_mode | input | 9 | Marker mode value |
| mark_priv | input | 1 | Marker comes from the privileged source |
| sw_away | input | 1 | Switch-away event pulse |
| away_by_yield | input | 1 | The switch away was started by a yield command |
| away_short | input | 1 | The switch away used the shortened save path |
| sw_back | input | 1 | Switch-back event pulse |
| launch_valid | output | 1 | Launch request pending |
| launch_addr | output | 64 | Buffer address |
| launch_len | output | 20 | Buffer length in dwords |
| launch_prot_off | output | 1 | Run the buffer with protected mode disabled |
| launch_ready | input | 1 | Launch accepted |
| err_pulse | output | 1 | One-cycle pulse for a refused write |

## Verification
The bench uses the package defaults: 32-bit payload dwords, 64-bit addresses, 20-bit lengths and four slots. With these values it can send addresses whose upper dword is non-zero and a length of 0xFFFFF, so it checks that both halves of the address and the full length field reach the launch port intact. Four slots cover every role code, so each switch cause can be driven against a set of fully populated slots and against slots emptied by a zero length.

// File: rtl/ctxsw_ib_pkg.sv
package ctxsw_ib_pkg;

    localparam int DW      = 32;
    localparam int ADDR_W  = 2 * DW;
    localparam int LEN_W   = 20;
    localparam int ROLE_W  = 2;
    localparam int MODE_W  = 9;
    localparam int NSLOT   = 1 << ROLE_W;
    localparam int WORDS   = 3;
    localparam int WCNT_W  = $clog2(WORDS);

    localparam logic [MODE_W-1:0] MODE_YIELD      = 9'h007;
    localparam logic [MODE_W-1:0] MODE_LIST_BEGIN = 9'h00D;
    localparam logic [MODE_W-1:0] MODE_LIST_DONE  = 9'h00E;
    localparam logic [MODE_W-1:0] MODE_PC_ON      = 9'h100;
    localparam logic [MODE_W-1:0] MODE_PC_OFF     = 9'h101;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_RESTORE  = 2'd0,
        ROLE_YRESTORE = 2'd1,
        ROLE_SAVE     = 2'd2,
        ROLE_RBSAVE   = 2'd3
    } slot_role_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } ib_desc_t;

    typedef struct packed {
        logic     prot_off;
        ib_desc_t desc;
    } launch_t;

    function automatic logic mode_is_privileged(input logic [MODE_W-1:0] m);
        return (m == MODE_LIST_BEGIN) || (m == MODE_LIST_DONE) ||
               (m == MODE_PC_ON) || (m == MODE_PC_OFF);
    endfunction

    function automatic logic desc_live(input ib_desc_t d);
        return d.len != '0;
    endfunction

endpackage

// File: rtl/ctxsw_pay_dec.sv
module ctxsw_pay_dec
    import ctxsw_ib_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          pay_valid,
    input  logic [DW-1:0] pay_data,
    input  logic          pay_priv,
    output logic          wr_en,
    output slot_role_e    wr_role,
    output ib_desc_t      wr_desc,
    output logic          bad
);
    logic [WCNT_W-1:0] word_idx;
    logic [DW-1:0]     addr_lo;
    logic [DW-1:0]     addr_hi;
    logic              last_word;

    assign last_word = pay_valid && (word_idx == WCNT_W'(WORDS - 1));
    assign wr_role   = slot_role_e'(pay_data[LEN_W +: ROLE_W]);
    assign wr_desc   = '{addr: {addr_hi, addr_lo}, len: pay_data[LEN_W-1:0]};
    assign bad       = last_word && (wr_role == ROLE_RBSAVE) && !pay_priv;
    assign wr_en     = last_word && !bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_idx <= '0;
            addr_lo  <= '0;
            addr_hi  <= '0;
        end else if (pay_valid) begin
            if (last_word) begin
                word_idx <= '0;
            end else begin
                word_idx <= word_idx + 1'b1;
            end
            if (word_idx == '0) addr_lo <= pay_data;
            if (word_idx == WCNT_W'(1)) addr_hi <= pay_data;
        end
    end
endmodule

// File: rtl/ctxsw_mark_trk.sv
module ctxsw_mark_trk
    import ctxsw_ib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mark_valid,
    input  logic [MODE_W-1:0] mark_mode,
    input  logic              mark_priv,
    output logic              yield_active,
    output logic              bad
);
    logic [MODE_W-1:0] cur_mode;

    assign bad          = mark_valid && !mark_priv && mode_is_privileged(mark_mode);
    assign yield_active = (cur_mode == MODE_YIELD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_mode <= '0;
        end else if (mark_valid && !bad) begin
            cur_mode <= mark_mode;
        end
    end
endmodule

// File: rtl/ctxsw_slot_bank.sv
module ctxsw_slot_bank
    import ctxsw_ib_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  slot_role_e            wr_role,
    input  ib_desc_t              wr_desc,
    output ib_desc_t [NSLOT-1:0]  slots
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[s] <= '0;
            end else if (wr_en && (wr_role == slot_role_e'(s))) begin
                slots[s] <= wr_desc;
            end
        end
    end
endmodule

// File: rtl/ctxsw_launch_seq.sv
module ctxsw_launch_seq
    import ctxsw_ib_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  ib_desc_t [NSLOT-1:0] slots,
    input  logic                 sw_away,
    input  logic                 away_by_yield,
    input  logic                 away_short,
    input  logic                 sw_back,
    input  logic                 yield_active,
    input  logic                 launch_ready,
    output logic                 launch_valid,
    output launch_t              launch_out
);
    logic    head_v, tail_v, yield_pre;
    launch_t head_q, tail_q;
    logic    idle, away_go, back_go, go;
    launch_t cand_a, cand_b;
    logic    a_ok, b_ok;

    assign idle    = !head_v;
    assign away_go = idle && sw_away;
    assign back_go = idle && sw_back && !sw_away;
    assign go      = away_go || back_go;

    always_comb begin
        cand_a = '0;
        cand_b = '0;
        a_ok   = 1'b0;
        b_ok   = 1'b0;
        if (away_go) begin
            cand_a = '{prot_off: 1'b1, desc: slots[ROLE_RBSAVE]};
            cand_b = '{prot_off: 1'b0, desc: slots[ROLE_SAVE]};
            a_ok   = !away_by_yield && desc_live(slots[ROLE_RBSAVE]);
            b_ok   = !away_by_yield && desc_live(slots[ROLE_SAVE]);
        end else if (back_go) begin
            cand_a = '{prot_off: 1'b0, desc: slots[ROLE_RESTORE]};
            cand_b = '{prot_off: 1'b0, desc: slots[ROLE_YRESTORE]};
            a_ok   = desc_live(slots[ROLE_RESTORE]);
            b_ok   = yield_pre && desc_live(slots[ROLE_YRESTORE]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_v    <= 1'b0;
            tail_v    <= 1'b0;
            head_q    <= '0;
            tail_q    <= '0;
            yield_pre <= 1'b0;
        end else begin
            if (away_go) yield_pre <= yield_active && away_short;
            if (back_go) yield_pre <= 1'b0;
            if (go) begin
                head_v <= a_ok || b_ok;
                head_q <= a_ok ? cand_a : cand_b;
                tail_v <= a_ok && b_ok;
                tail_q <= cand_b;
            end else if (head_v && launch_ready) begin
                head_v <= tail_v;
                head_q <= tail_q;
                tail_v <= 1'b0;
            end
        end
    end

    assign launch_valid = head_v;
    assign launch_out   = head_v ? head_q : '0;
endmodule

// File: rtl/ctxsw_ib_sel.sv
module ctxsw_ib_sel
    import ctxsw_ib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pay_valid,
    input  logic [DW-1:0]     pay_data,
    input  logic              pay_priv,
    input  logic              mark_valid,
    input  logic [MODE_W-1:0] mark_mode,
    input  logic              mark_priv,
    input  logic              sw_away,
    input  logic              away_by_yield,
    input  logic              away_short,
    input  logic              sw_back,
    output logic              launch_valid,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [LEN_W-1:0]  launch_len,
    output logic              launch_prot_off,
    input  logic              launch_ready,
    output logic              err_pulse
);
    logic                 wr_en, pay_bad, mark_bad, yield_active;
    slot_role_e           wr_role;
    ib_desc_t             wr_desc;
    ib_desc_t [NSLOT-1:0] slots;
    launch_t              launch_out;

    ctxsw_pay_dec u_dec (
        .clk(clk), .rst(rst), .pay_valid(pay_valid), .pay_data(pay_data),
        .pay_priv(pay_priv), .wr_en(wr_en), .wr_role(wr_role),
        .wr_desc(wr_desc), .bad(pay_bad)
    );

    ctxsw_mark_trk u_mark (
        .clk(clk), .rst(rst), .mark_valid(mark_valid), .mark_mode(mark_mode),
        .mark_priv(mark_priv), .yield_active(yield_active), .bad(mark_bad)
    );

    ctxsw_slot_bank u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_role(wr_role),
        .wr_desc(wr_desc), .slots(slots)
    );

    ctxsw_launch_seq u_seq (
        .clk(clk), .rst(rst), .slots(slots), .sw_away(sw_away),
        .away_by_yield(away_by_yield), .away_short(away_short),
        .sw_back(sw_back), .yield_active(yield_active),
        .launch_ready(launch_ready), .launch_valid(launch_valid),
        .launch_out(launch_out)
    );

    always_ff @(posedge clk) begin
        if (rst) err_pulse <= 1'b0;
        else     err_pulse <= pay_bad || mark_bad;
    end

    assign launch_addr     = launch_out.desc.addr;
    assign launch_len      = launch_out.desc.len;
    assign launch_prot_off = launch_out.prot_off;
endmodule

// File: rtl/ctxsw_ib_sel_chk.sv
module ctxsw_ib_sel_chk
    import ctxsw_ib_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pay_valid,
    input logic              mark_valid,
    input logic              sw_away,
    input logic              sw_back,
    input logic              launch_valid,
    input logic [ADDR_W-1:0] launch_addr,
    input logic [LEN_W-1:0]  launch_len,
    input logic              launch_prot_off,
    input logic              launch_ready,
    input logic              err_pulse
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (launch_valid && !launch_ready) |=> (launch_valid && $stable(launch_addr) &&
        $stable(launch_len) && $stable(launch_prot_off)));

    assert_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
        launch_valid |-> (launch_len != '0));

    assert_err_src_R2: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(pay_valid || mark_valid));

    assert_launch_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(launch_valid) |-> $past(sw_away || sw_back));

    assert_prot_R7: assert property (@(posedge clk) disable iff (rst)
        launch_prot_off |-> launch_valid);
endmodule

bind ctxsw_ib_sel ctxsw_ib_sel_chk u_chk (
    .clk(clk), .rst(rst), .pay_valid(pay_valid), .mark_valid(mark_valid),
    .sw_away(sw_away), .sw_back(sw_back), .launch_valid(launch_valid),
    .launch_addr(launch_addr), .launch_len(launch_len),
    .launch_prot_off(launch_prot_off), .launch_ready(launch_ready),
    .err_pulse(err_pulse)
);

// File: tb/ctxsw_ib_sel_bench.sv
`timescale 1ns/1ps
module ctxsw_ib_sel_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pay_valid = 0, pay_priv = 0, mark_valid = 0, mark_priv = 0;
    logic [31:0] pay_data = '0;
    logic [8:0]  mark_mode = '0;
    logic        sw_away = 0, away_by_yield = 0, away_short = 0, sw_back = 0;
    logic        launch_ready = 0;
    logic        launch_valid, launch_prot_off, err_pulse;
    logic [63:0] launch_addr;
    logic [19:0] launch_len;
    int checks = 0, errors = 0;
    bit done = 0;

    localparam logic [63:0] A_RST = 64'h0000_0001_0000_1000;
    localparam logic [63:0] A_YRS = 64'h0000_0002_0000_2000;
    localparam logic [63:0] A_SAV = 64'h0000_0003_0000_3000;
    localparam logic [63:0] A_RBS = 64'hFFFF_0004_0000_4000;
    localparam logic [63:0] A_BAD = 64'h0BAD_0BAD_0BAD_0BAD;
    localparam logic [63:0] A_NEW = 64'h8000_0000_DEAD_BEE0;

    always #2 clk = ~clk;

    ctxsw_ib_sel u_ctxsw_ib_sel (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_payload(input logic [63:0] addr, input logic [19:0] len,
                                input logic [1:0] role, input bit priv, output bit err);
        logic [31:0] words [3];
        words[0] = addr[31:0];
        words[1] = addr[63:32];
        words[2] = {10'd0, role, len};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            pay_valid = 1; pay_data = words[i]; pay_priv = priv;
        end
        @(negedge clk);
        pay_valid = 0; pay_priv = 0;
        err = err_pulse;
    endtask

    task automatic set_marker(input logic [8:0] mode, input bit priv, output bit err);
        @(negedge clk);
        mark_valid = 1; mark_mode = mode; mark_priv = priv;
        @(negedge clk);
        mark_valid = 0; mark_priv = 0;
        err = err_pulse;
    endtask

    task automatic ev_away(input bit yld, input bit shrt);
        @(negedge clk);
        sw_away = 1; away_by_yield = yld; away_short = shrt;
        @(negedge clk);
        sw_away = 0; away_by_yield = 0; away_short = 0;
    endtask

    task automatic ev_back();
        @(negedge clk);
        sw_back = 1;
        @(negedge clk);
        sw_back = 0;
    endtask

    task automatic expect_launch(input logic [63:0] addr, input logic [19:0] len,
                                 input bit prot, input string req);
        check(launch_valid === 1'b1, req, "launch_valid", 64'(launch_valid), 64'd1);
        check(launch_addr === addr, req, "launch_addr", launch_addr, addr);
        check(launch_len === len, req, "launch_len", 64'(launch_len), 64'(len));
        check(launch_prot_off === prot, req, "prot_off", 64'(launch_prot_off), 64'(prot));
        launch_ready = 1;
        @(negedge clk);
        launch_ready = 0;
    endtask

    task automatic expect_idle(input string req);
        check(launch_valid === 1'b0, req, "idle", 64'(launch_valid), 64'd0);
    endtask

    task automatic t_reset();
        check(launch_valid === 0 && err_pulse === 0, "R12", "reset outputs",
              64'({launch_valid, err_pulse}), 64'd0);
        ev_away(0, 0);
        expect_idle("R8 empty after reset (away)");
        ev_back();
        expect_idle("R8 empty after reset (back)");
    endtask

    task automatic t_load();
        bit e;
        send_payload(A_RST, 20'd10, 2'd0, 0, e);
        check(e == 0, "R1", "err on restore write", 64'(e), 0);
        send_payload(A_YRS, 20'd20, 2'd1, 0, e);
        send_payload(A_SAV, 20'd30, 2'd2, 0, e);
        send_payload(A_RBS, 20'hFFFFF, 2'd3, 1, e);
        check(e == 0, "R1", "err on priv rb write", 64'(e), 0);
    endtask

    task automatic t_away_normal();
        ev_away(0, 0);
        expect_launch(A_RBS, 20'hFFFFF, 1, "R6 R7 rb save first");
        expect_launch(A_SAV, 20'd30, 0, "R6 save second");
        expect_idle("R6 done");
        ev_back();
        expect_launch(A_RST, 20'd10, 0, "R4 restore");
        expect_idle("R5 no yield-restore without preempt");
    endtask

    task automatic t_yield();
        bit e;
        set_marker(9'd7, 1, e);
        ev_away(1, 1);
        expect_idle("R6 yield-caused away launches nothing");
        ev_back();
        expect_launch(A_RST, 20'd10, 0, "R4 restore before yield-restore");
        expect_launch(A_YRS, 20'd20, 0, "R5 yield-restore");
        expect_idle("R5 end");
        ev_back();
        expect_launch(A_RST, 20'd10, 0, "R10 restore again");
        expect_idle("R10 flag cleared");
        ev_away(1, 0);
        ev_back();
        expect_launch(A_RST, 20'd10, 0, "R5 restore (no short save)");
        expect_idle("R5 no yield-restore without short save");
    endtask

    task automatic t_priv();
        bit e;
        send_payload(A_BAD, 20'd5, 2'd3, 0, e);
        check(e == 1, "R2", "err on unpriv rb write", 64'(e), 1);
        @(negedge clk);
        check(err_pulse === 0, "R2", "err one cycle", 64'(err_pulse), 0);
        ev_away(0, 0);
        expect_launch(A_RBS, 20'hFFFFF, 1, "R2 rb slot unchanged");
        expect_launch(A_SAV, 20'd30, 0, "R2 save");
        ev_back();
        expect_launch(A_RST, 20'd10, 0, "R2 restore");
        set_marker(9'h100, 0, e);
        check(e == 1, "R3", "err on unpriv 0x100", 64'(e), 1);
        ev_away(0, 1);
        expect_launch(A_RBS, 20'hFFFFF, 1, "R3 rb");
        expect_launch(A_SAV, 20'd30, 0, "R3 save");
        ev_back();
        expect_launch(A_RST, 20'd10, 0, "R3 restore");
        expect_launch(A_YRS, 20'd20, 0, "R3 mode kept at 7");
        set_marker(9'h005, 0, e);
        check(e == 0, "R3", "no err on unpriv 0x005", 64'(e), 0);
        ev_away(1, 1);
        ev_back();
        expect_launch(A_RST, 20'd10, 0, "R3 restore");
        expect_idle("R3 mode replaced by 0x005");
        set_marker(9'h00D, 1, e);
        check(e == 0, "R3", "no err on priv 0x00D", 64'(e), 0);
    endtask

    task automatic t_hold();
        ev_away(0, 0);
        repeat (3) @(negedge clk);
        check(launch_valid === 1 && launch_addr === A_RBS, "R9", "held without ready",
              launch_addr, A_RBS);
        @(negedge clk); sw_back = 1;
        @(negedge clk); sw_back = 0;
        expect_launch(A_RBS, 20'hFFFFF, 1, "R9 rb");
        expect_launch(A_SAV, 20'd30, 0, "R9 save next cycle");
        expect_idle("R11 back during launch ignored");
    endtask

    task automatic t_empty();
        bit e;
        send_payload(A_NEW, 20'd0, 2'd2, 0, e);
        @(negedge clk);
        sw_away = 1; sw_back = 1;
        @(negedge clk);
        sw_away = 0; sw_back = 0;
        expect_launch(A_RBS, 20'hFFFFF, 1, "R11 away wins");
        expect_idle("R8 zero-length save skipped; R11 back ignored");
        send_payload(A_NEW, 20'h12345, 2'd0, 0, e);
        ev_back();
        expect_launch(A_NEW, 20'h12345, 0, "R1 overwritten restore");
        expect_idle("R1 end");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_load();
        t_away_normal();
        t_yield();
        t_priv();
        t_hold();
        t_empty();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule